// File: doc/BRIEF.md
# VSWR fault prioritizer and stretcher

This block accepts two asynchronous, active-low reflected-power trip signals: one from the bandpass filter detector and one from the antenna detector. It brings both into the clock domain and resolves a coincidence in favour of the antenna. It then forms one active-low combined trip strobe. That strobe serves as the PA shutdown request and as the set input of a self-test latch, and it is also provided as an active-high `pa_off`. On each new fault episode the strobe also fires a single, fixed-width RF drive switch-over pulse toward the oscillator.

Each channel has its own retriggerable one-shot that widens a short trip into a status pulse of `STRETCH_CYC` clock cycles, which is long enough to light an indicator. Both polarities are provided, so that one pair can feed the front panel and the external terminal. An active-low supply-fault input, which is low during power-up, keeps both one-shots from firing and clears them.

Each one-shot is a two-state machine. The states are `STR_IDLE` and `STR_HOLD`. The transitions are:
- *arm*: `STR_IDLE`→`STR_HOLD` on a rising edge of the channel fault while the supply is good.
- *restart*: `STR_HOLD`→`STR_HOLD` with the counter reloaded, on a new rising edge.
- *expire*: `STR_HOLD`→`STR_IDLE` when the counter reaches zero.
- *inhibit*: any state→`STR_IDLE` while the supply fault is present.

The switch-over generator is a three-state machine. The states are `SW_IDLE`, `SW_PULSE` and `SW_HOLDOFF`. The transitions are:
- *fire*: `SW_IDLE`→`SW_PULSE` when the combined fault appears.
- *done*: `SW_PULSE`→`SW_HOLDOFF` after `SWAP_CYC` cycles.
- *clear*: `SW_HOLDOFF`→`SW_IDLE` once the combined fault has gone.

Top module: `vswr_guard`

## Requirements
- R1: After reset, the outputs are as follows: `trip_any_n`=1, `pa_off`=0, `swap_pulse`=0, `filt_stat`=0, `ant_stat`=0, `filt_stat_n`=1 and `ant_stat_n`=1.
- R2: A trip input is active low. Suppose a trip input is driven low between clock edges. Then `trip_any_n` goes low and `pa_off` goes high after the third following rising edge, and both return to idle three edges after the input is released.
- R3: If both trip inputs are low in the same synchronized cycle, only the antenna fault is reported. In that case `filt_stat` does not rise, while `ant_stat` and `trip_any_n` respond.
- R4: A filter-only trip is reported on the filter channel and not on the antenna channel.
- R5: `swap_pulse` goes high one edge after `trip_any_n` falls. It stays high for exactly `SWAP_CYC` cycles. It does not fire again until `trip_any_n` has returned high.
- R6: A rising edge of a channel's reported fault drives that channel's status high, one edge after the fault is reported. The status stays high for exactly `STRETCH_CYC` cycles, and the `_n` output is always its complement.
- R7: A new rising edge during the status pulse restarts the full `STRETCH_CYC` interval, counted from the new edge.
- R8: While `supply_fault_n` is low (after two synchronizing edges), the stretchers cannot be triggered, and any running status pulse is cleared.
- R9: A fault held low steadily does not retrigger the stretcher. The status falls `STRETCH_CYC` cycles after the first edge even though the fault is still present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| filt_trip_n | input | 1 | Bandpass filter trip, asynchronous, active low |
| ant_trip_n | input | 1 | Antenna trip, asynchronous, active low |
| supply_fault_n | input | 1 | Supply fault, asynchronous, active low; inhibits stretchers |
| trip_any_n | output | 1 | Combined trip strobe, active low (PA off, self-test latch set) |
| pa_off | output | 1 | Combined trip, active high |
| swap_pulse | output | 1 | RF drive switch-over pulse, active high |
| filt_stat | output | 1 | Stretched filter status, active high |
| filt_stat_n | output | 1 | Stretched filter status, active low |
| ant_stat | output | 1 | Stretched antenna status, active high |
| ant_stat_n | output | 1 | Stretched antenna status, active low |

## Verification
A one-shot that sits in the wrong state shows up at a status pin on the very next edge. If its counter is loaded or decremented incorrectly, the status pulse is shorter or longer than expected, and this shows only at the expected falling edge, `STRETCH_CYC` cycles after the trigger. The bench therefore samples both one cycle before and at that edge, and at the shifted edge after a restart. If the switch-over machine leaves `SW_HOLDOFF` too early, a second pulse appears while the trip is still held. If the priority stage is wrong, the filter status lights during a coincident trip, within four edges of the inputs.

// File: rtl/vswr_guard_pkg.sv
package vswr_guard_pkg;

    typedef enum logic {
        STR_IDLE,
        STR_HOLD
    } str_state_e;

    typedef enum logic [1:0] {
        SW_IDLE,
        SW_PULSE,
        SW_HOLDOFF
    } swap_state_e;

    localparam int NUM_CHAN = 2;
    localparam int CH_FILT  = 0;
    localparam int CH_ANT   = 1;

    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/vswr_sync.sv
module vswr_sync #(
    parameter int         WIDTH   = 1,
    parameter int         STAGES  = 2,
    parameter logic       RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage[i] <= {WIDTH{RST_VAL}};
            end
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stage[i] <= stage[i-1];
            end
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/vswr_prio.sv
module vswr_prio (
    input  logic clk,
    input  logic rst_n,
    input  logic filt_hit,
    input  logic ant_hit,
    output logic filt_valid,
    output logic ant_valid
);

    logic coincide;

    // Coincidence detect; the antenna path goes through the same
    // register stage so both channels stay aligned with no glitch.
    always_comb begin
        coincide = filt_hit & ant_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_valid <= 1'b0;
            ant_valid  <= 1'b0;
        end else begin
            filt_valid <= filt_hit & ~coincide;
            ant_valid  <= ant_hit;
        end
    end

    // R3: the two reported faults are never both active
    p_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(filt_valid && ant_valid));

endmodule

// File: rtl/vswr_stretch.sv
module vswr_stretch
    import vswr_guard_pkg::*;
#(
    parameter int LEN = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic enable,
    output logic pulse,
    output logic pulse_n
);

    localparam int          CW     = cnt_width(LEN);
    localparam logic [CW-1:0] RELOAD = CW'(LEN - 1);

    str_state_e    state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic          trig_q;
    logic          rise;

    assign rise = trig & ~trig_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= STR_IDLE;
            cnt    <= '0;
            trig_q <= 1'b0;
        end else begin
            state  <= state_nx;
            cnt    <= cnt_nx;
            trig_q <= trig;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        if (!enable) begin
            state_nx = STR_IDLE;           // inhibit
            cnt_nx   = '0;
        end else begin
            unique case (state)
                STR_IDLE: begin
                    if (rise) begin        // arm
                        state_nx = STR_HOLD;
                        cnt_nx   = RELOAD;
                    end
                end
                STR_HOLD: begin
                    if (rise) begin        // restart
                        cnt_nx = RELOAD;
                    end else if (cnt == '0) begin
                        state_nx = STR_IDLE;   // expire
                    end else begin
                        cnt_nx = cnt - 1'b1;
                    end
                end
                default: state_nx = STR_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        pulse   = (state == STR_HOLD);
        pulse_n = ~pulse;
    end

    // R6: pulse holds while time remains
    p_hold_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == STR_HOLD && cnt != '0 && enable) |=> pulse);

    // R7: a new edge reloads the whole interval
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && enable) |=> (pulse && cnt == RELOAD));

    // R8: supply fault clears and blocks the one-shot
    p_inhibit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable) |=> !pulse);

    // R9: a steady level never arms an idle one-shot
    p_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == STR_IDLE && trig && trig_q) |=> !pulse);

endmodule

// File: rtl/vswr_swap.sv
module vswr_swap
    import vswr_guard_pkg::*;
#(
    parameter int LEN = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault,
    output logic pulse
);

    localparam int            CW     = cnt_width(LEN);
    localparam logic [CW-1:0] RELOAD = CW'(LEN - 1);

    swap_state_e   state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SW_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            SW_IDLE: begin
                if (fault) begin           // fire
                    state_nx = SW_PULSE;
                    cnt_nx   = RELOAD;
                end
            end
            SW_PULSE: begin
                if (cnt == '0) begin
                    state_nx = SW_HOLDOFF; // done
                end else begin
                    cnt_nx = cnt - 1'b1;
                end
            end
            SW_HOLDOFF: begin
                if (!fault) begin
                    state_nx = SW_IDLE;    // clear
                end
            end
            default: state_nx = SW_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pulse = (state == SW_PULSE);
    end

    // R5: pulse width held while time remains
    p_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SW_PULSE && cnt != '0) |=> pulse);

    // R5: no second pulse while the same fault is held
    p_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SW_HOLDOFF && fault) |=> !pulse);

endmodule

// File: rtl/vswr_guard.sv
module vswr_guard
    import vswr_guard_pkg::*;
#(
    parameter int STRETCH_CYC = 50_000_000,
    parameter int SWAP_CYC    = 1_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic filt_trip_n,
    input  logic ant_trip_n,
    input  logic supply_fault_n,
    output logic trip_any_n,
    output logic pa_off,
    output logic swap_pulse,
    output logic filt_stat,
    output logic filt_stat_n,
    output logic ant_stat,
    output logic ant_stat_n
);

    logic [2:0]          raw_n, sync_n;
    logic                filt_valid, ant_valid;
    logic                supply_ok;
    logic                any_fault;
    logic [NUM_CHAN-1:0] chan_valid, stat, stat_n;

    assign raw_n = {supply_fault_n, ant_trip_n, filt_trip_n};

    vswr_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_n),
        .q     (sync_n)
    );

    assign supply_ok = sync_n[2];

    vswr_prio u_prio (
        .clk        (clk),
        .rst_n      (rst_n),
        .filt_hit   (~sync_n[0]),
        .ant_hit    (~sync_n[1]),
        .filt_valid (filt_valid),
        .ant_valid  (ant_valid)
    );

    assign chan_valid[CH_FILT] = filt_valid;
    assign chan_valid[CH_ANT]  = ant_valid;

    always_comb begin
        any_fault  = |chan_valid;
        trip_any_n = ~any_fault;
        pa_off     = any_fault;
    end

    vswr_swap #(
        .LEN (SWAP_CYC)
    ) u_swap (
        .clk   (clk),
        .rst_n (rst_n),
        .fault (any_fault),
        .pulse (swap_pulse)
    );

    for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
        vswr_stretch #(
            .LEN (STRETCH_CYC)
        ) u_stretch (
            .clk     (clk),
            .rst_n   (rst_n),
            .trig    (chan_valid[ch]),
            .enable  (supply_ok),
            .pulse   (stat[ch]),
            .pulse_n (stat_n[ch])
        );
    end

    assign filt_stat   = stat[CH_FILT];
    assign filt_stat_n = stat_n[CH_FILT];
    assign ant_stat    = stat[CH_ANT];
    assign ant_stat_n  = stat_n[CH_ANT];

    // R2: combined strobe and shutdown output always agree
    p_strobe_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pa_off != trip_any_n);

    // R5: switch-over only follows a present fault
    p_swap_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(swap_pulse) |-> $past(!trip_any_n));

endmodule

// File: tb/vswr_guard_test.sv
`timescale 1ns/1ps
module vswr_guard_test;

    localparam int S  = 20;
    localparam int SW = 5;

    logic clk = 1'b0;
    logic rst_n;
    logic filt_trip_n, ant_trip_n, supply_fault_n;
    logic trip_any_n, pa_off, swap_pulse;
    logic filt_stat, filt_stat_n, ant_stat, ant_stat_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    vswr_guard #(
        .STRETCH_CYC (S),
        .SWAP_CYC    (SW)
    ) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .filt_trip_n    (filt_trip_n),
        .ant_trip_n     (ant_trip_n),
        .supply_fault_n (supply_fault_n),
        .trip_any_n     (trip_any_n),
        .pa_off         (pa_off),
        .swap_pulse     (swap_pulse),
        .filt_stat      (filt_stat),
        .filt_stat_n    (filt_stat_n),
        .ant_stat       (ant_stat),
        .ant_stat_n     (ant_stat_n)
    );

    // {filt_n, ant_n, sup_n, wait[7:0], 2'b00, exp_trip_n, exp_fs, exp_as}
    localparam int NV = 10;
    localparam logic [15:0] VEC [NV] = '{
        {1'b1, 1'b1, 1'b1, 8'd30, 2'b00, 1'b1, 1'b0, 1'b0},  // idle
        {1'b0, 1'b1, 1'b1, 8'd4,  2'b00, 1'b0, 1'b1, 1'b0},  // filter only R4
        {1'b1, 1'b1, 1'b1, 8'd4,  2'b00, 1'b1, 1'b1, 1'b0},  // release, stretched R2
        {1'b1, 1'b1, 1'b1, 8'd20, 2'b00, 1'b1, 1'b0, 1'b0},  // expired R6
        {1'b0, 1'b0, 1'b1, 8'd4,  2'b00, 1'b0, 1'b0, 1'b1},  // both: antenna wins R3
        {1'b1, 1'b1, 1'b1, 8'd30, 2'b00, 1'b1, 1'b0, 1'b0},  // idle
        {1'b1, 1'b1, 1'b0, 8'd4,  2'b00, 1'b1, 1'b0, 1'b0},  // supply fault
        {1'b1, 1'b0, 1'b0, 8'd6,  2'b00, 1'b0, 1'b0, 1'b0},  // blocked R8
        {1'b1, 1'b1, 1'b0, 8'd6,  2'b00, 1'b1, 1'b0, 1'b0},
        {1'b1, 1'b1, 1'b1, 8'd4,  2'b00, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        filt_trip_n = 1'b1;
        ant_trip_n = 1'b1;
        supply_fault_n = 1'b1;
        cyc(5);
        // R1 reset state
        chk("R1 trip_any_n", trip_any_n, 1'b1);
        chk("R1 pa_off", pa_off, 1'b0);
        chk("R1 swap_pulse", swap_pulse, 1'b0);
        chk("R1 filt_stat", filt_stat, 1'b0);
        chk("R1 filt_stat_n", filt_stat_n, 1'b1);
        chk("R1 ant_stat", ant_stat, 1'b0);
        chk("R1 ant_stat_n", ant_stat_n, 1'b1);
        rst_n = 1'b1;

        // table walk
        for (int i = 0; i < NV; i++) begin
            filt_trip_n    = VEC[i][15];
            ant_trip_n     = VEC[i][14];
            supply_fault_n = VEC[i][13];
            cyc(int'(VEC[i][12:5]));
            chk($sformatf("R2 vec%0d trip_any_n", i), trip_any_n, VEC[i][2]);
            chk($sformatf("R3/R4 vec%0d filt_stat", i), filt_stat, VEC[i][1]);
            chk($sformatf("R3/R4 vec%0d ant_stat", i), ant_stat, VEC[i][0]);
        end
        cyc(40);

        // R2 latency: not yet at edge 2, present at edge 3
        filt_trip_n = 1'b0;
        cyc(2);
        chk("R2 trip before latency", trip_any_n, 1'b1);
        cyc(1);
        chk("R2 trip after 3 edges", trip_any_n, 1'b0);
        chk("R2 pa_off", pa_off, 1'b1);
        // R6 length with a held fault (R9 steady level)
        cyc(1);                                   // t=4
        chk("R6 filt_stat rise", filt_stat, 1'b1);
        chk("R6 filt_stat_n low", filt_stat_n, 1'b0);
        cyc(S - 1);                               // t=23
        chk("R6 filt_stat last cycle", filt_stat, 1'b1);
        cyc(1);                                   // t=24
        chk("R9 held fault no retrigger", filt_stat, 1'b0);
        chk("R6 filt_stat_n restored", filt_stat_n, 1'b1);
        filt_trip_n = 1'b1;
        cyc(40);

        // R7 restart
        filt_trip_n = 1'b0;
        cyc(2);
        filt_trip_n = 1'b1;
        cyc(8);                                   // t=10
        filt_trip_n = 1'b0;
        cyc(2);
        filt_trip_n = 1'b1;
        cyc(18);                                  // t=30
        chk("R7 still high after restart", filt_stat, 1'b1);
        cyc(3);                                   // t=33
        chk("R7 last cycle of restarted interval", filt_stat, 1'b1);
        cyc(1);                                   // t=34
        chk("R7 falls after restarted interval", filt_stat, 1'b0);
        cyc(40);

        // R5 switch-over pulse
        ant_trip_n = 1'b0;
        cyc(3);
        chk("R5 swap not before fault", swap_pulse, 1'b0);
        cyc(1);                                   // t=4
        chk("R5 swap rise", swap_pulse, 1'b1);
        cyc(4);                                   // t=8
        chk("R5 swap last cycle", swap_pulse, 1'b1);
        cyc(1);                                   // t=9
        chk("R5 swap fall", swap_pulse, 1'b0);
        cyc(5);                                   // t=14
        chk("R5 no refire while held", swap_pulse, 1'b0);
        cyc(1);                                   // t=15
        ant_trip_n = 1'b1;
        cyc(5);                                   // t=20
        ant_trip_n = 1'b0;
        cyc(4);                                   // t=24
        chk("R5 fires on new episode", swap_pulse, 1'b1);
        ant_trip_n = 1'b1;
        cyc(40);

        // R8 supply fault clears a running pulse
        filt_trip_n = 1'b0;
        cyc(2);
        filt_trip_n = 1'b1;
        cyc(2);                                   // t=4
        chk("R8 armed before inhibit", filt_stat, 1'b1);
        cyc(4);                                   // t=8
        supply_fault_n = 1'b0;
        cyc(4);                                   // t=12
        chk("R8 cleared by supply fault", filt_stat, 1'b0);
        chk("R8 complement", filt_stat_n, 1'b1);
        supply_fault_n = 1'b1;
        cyc(10);

        finish_run();
    end

endmodule